// File: doc/BRIEF.md
# Condition-Code ALU with Flag-Driven Branch Resolution

This block is a 32-bit integer arithmetic and logic unit that keeps a small set of persistent one-bit condition flags. Every valid operation produces its result combinationally in the same cycle. At the next clock edge it also records what it learned about that result: sign, zero, carry, signed overflow and the parity of the low byte. A compare operation runs the subtractor only to refresh those flags and never asks for a destination write.

A separate branch query chooses one of six relations: equal, not equal, less, less-or-equal, greater and greater-or-equal. It answers taken or not taken from the stored flags alone, with no operand comparison at branch time. Because ordinary arithmetic updates the flags as a side effect, a branch can test the outcome of an add or a decrement directly. Fetch, decode and program-counter redirection belong to the surrounding pipeline.

Top module: `flag_alu`

## Requirements
- R1: Operation codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 shift left logical, 6 shift right logical, 7 shift right arithmetic, 8 increment, 9 decrement and 10 compare. For every legal code the result appears on `res_data` in the same cycle. Shift amounts come from `op_b[4:0]`. `res_write` is high for a valid legal operation other than compare.
- R2: After a flag update, sign equals bit 31 of the result and zero is 1 when all 32 result bits are 0. Parity is 1 when bits 7..0 of the result hold an even number of ones.
- R3: Add stores its carry out in the carry flag. Subtract and compare store a borrow, so carry is 1 exactly when `op_a < op_b` unsigned. Add, subtract, compare, increment and decrement store signed two's-complement overflow in the overflow flag.
- R4: Compare updates all flags exactly as subtract would, and holds `res_write` low.
- R5: AND, OR and XOR clear both carry and overflow.
- R6: Increment and decrement leave the carry flag at its previous value and update all other flags.
- R7: For a shift by a nonzero amount, carry takes the last bit shifted out. A shift by zero keeps carry. Every shift clears overflow.
- R8: Branch codes on `br_cond` are 0 equal (zero), 1 not equal (not zero), 2 less (sign XOR overflow), 3 less-or-equal (less or zero), 4 greater (neither less nor zero) and 5 greater-or-equal (not less). Codes 6 and 7 are never taken. `br_taken` follows the stored flags combinationally.
- R9: Flags change only at a clock edge where `op_valid` is high and the code is 0 to 10. Codes 11 to 15 drive `res_data` to 0, hold `res_write` low and leave the flags unchanged.
- R10: Reset clears all five flags. Directly after reset, equal, less and less-or-equal are not taken, while not equal, greater and greater-or-equal are taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand or shift amount |
| br_cond | input | 3 | Branch relation select |
| res_data | output | 32 | Combinational result |
| res_write | output | 1 | Result should be written to a destination |
| br_taken | output | 1 | Selected relation holds on the stored flags |
| flag_sign | output | 1 | Stored sign flag |
| flag_zero | output | 1 | Stored zero flag |
| flag_carry | output | 1 | Stored carry/borrow flag |
| flag_ovf | output | 1 | Stored signed-overflow flag |
| flag_parity | output | 1 | Stored low-byte parity flag |

## Verification
`res_data` and `res_write` are due in the same cycle as the operands. The bench therefore samples them one nanosecond after driving at the falling edge. The flags and `br_taken` change only after the next rising edge, so the bench advances its reference flags at that edge and compares them shortly afterwards. It then sweeps all eight branch codes, each sampled after it settles, before the next falling edge drives new operands. Cycles with `op_valid` low and cycles with reserved codes go through the same path, which shows that the stored flags did not move.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

   localparam logic [3:0] OP_ADD = 4'd0;
   localparam logic [3:0] OP_SUB = 4'd1;
   localparam logic [3:0] OP_AND = 4'd2;
   localparam logic [3:0] OP_OR  = 4'd3;
   localparam logic [3:0] OP_XOR = 4'd4;
   localparam logic [3:0] OP_SLL = 4'd5;
   localparam logic [3:0] OP_SRL = 4'd6;
   localparam logic [3:0] OP_SRA = 4'd7;
   localparam logic [3:0] OP_INC = 4'd8;
   localparam logic [3:0] OP_DEC = 4'd9;
   localparam logic [3:0] OP_CMP = 4'd10;
   localparam logic [3:0] OP_LAST = OP_CMP;

   localparam logic [2:0] BR_EQ = 3'd0;
   localparam logic [2:0] BR_NE = 3'd1;
   localparam logic [2:0] BR_LT = 3'd2;
   localparam logic [2:0] BR_LE = 3'd3;
   localparam logic [2:0] BR_GT = 3'd4;
   localparam logic [2:0] BR_GE = 3'd5;

   localparam logic [1:0] AR_ADD = 2'd0;
   localparam logic [1:0] AR_SUB = 2'd1;
   localparam logic [1:0] AR_INC = 2'd2;
   localparam logic [1:0] AR_DEC = 2'd3;

   localparam logic [1:0] SH_LEFT  = 2'd0;
   localparam logic [1:0] SH_RLOG  = 2'd1;
   localparam logic [1:0] SH_RARI  = 2'd2;

   typedef enum logic [1:0] {
      CY_ARITH,
      CY_CLEAR,
      CY_SHIFT,
      CY_KEEP
   } carry_src_e;

   typedef struct packed {
      logic ovf;
      logic par;
      logic cy;
      logic zero;
      logic sign;
   } cc_t;

   function automatic logic code_is_legal(input logic [3:0] code);
      return code <= OP_LAST;
   endfunction

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
   import flag_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   mode,
   output logic [W-1:0] sum,
   output logic         carry,
   output logic         ovf
);

   logic [W-1:0] b_eff;
   logic         cin;
   logic [W:0]   ext;

   always_comb begin
      case (mode)
         AR_SUB:  begin b_eff = ~b;        cin = 1'b1; end
         AR_INC:  begin b_eff = '0;        cin = 1'b1; end
         AR_DEC:  begin b_eff = '1;        cin = 1'b0; end
         default: begin b_eff = b;         cin = 1'b0; end
      endcase
   end

   assign ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
   assign sum   = ext[W-1:0];
   // subtraction reports a borrow rather than the raw carry out
   assign carry = (mode == AR_SUB) ? ~ext[W] : ext[W];
   assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift
   import flag_alu_pkg::*;
#(
   parameter int W      = 32,
   parameter bit BARREL = 1'b1,
   localparam int SH_W  = $clog2(W)
) (
   input  logic [W-1:0]    a,
   input  logic [SH_W-1:0] amt,
   input  logic [1:0]      kind,
   output logic [W-1:0]    res,
   output logic            cout,
   output logic            moved
);

   // Each side is one bit wider than the operand: the extra bit
   // catches the last bit that falls off the end.
   logic [W:0] left_v;
   logic [W:0] right_v;
   logic       fill;

   assign fill = (kind == SH_RARI) && a[W-1];

   generate
      if (BARREL) begin : g_barrel
         for (genvar k = 0; k < SH_W; k++) begin : stg
            localparam int STEP = 1 << k;
            logic [W:0] l_in, l_out, r_in, r_out;
            if (k == 0) begin : g_first
               assign l_in = {1'b0, a};
               assign r_in = {a, 1'b0};
            end else begin : g_next
               assign l_in = stg[k-1].l_out;
               assign r_in = stg[k-1].r_out;
            end
            assign l_out = amt[k] ? {l_in[W-STEP:0], {STEP{1'b0}}} : l_in;
            assign r_out = amt[k] ? {{STEP{fill}}, r_in[W:STEP]} : r_in;
         end
         assign left_v  = stg[SH_W-1].l_out;
         assign right_v = stg[SH_W-1].r_out;
      end else begin : g_operator
         logic signed [W:0] r_signed;
         assign left_v   = {1'b0, a} << amt;
         assign r_signed = $signed({a, 1'b0}) >>> amt;
         assign right_v  = (kind == SH_RARI) ? $unsigned(r_signed)
                                             : ({a, 1'b0} >> amt);
      end
   endgenerate

   assign res   = (kind == SH_LEFT) ? left_v[W-1:0] : right_v[W:1];
   assign cout  = (kind == SH_LEFT) ? left_v[W] : right_v[0];
   assign moved = (amt != '0);

endmodule

// File: rtl/flag_alu_ccreg.sv
module flag_alu_ccreg
   import flag_alu_pkg::*;
#(
   parameter int W     = 32,
   parameter int PAR_W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd,
   input  logic [W-1:0] result,
   input  logic         cy_next,
   input  logic         ovf_next,
   output cc_t          flags_q
);

   cc_t  nxt;
   logic even_ones;

   generate
      if (PAR_W == 1) begin : g_par_bit
         assign even_ones = ~result[0];
      end else begin : g_par_tree
         assign even_ones = ~^result[PAR_W-1:0];
      end
   endgenerate

   always_comb begin
      nxt.sign = result[W-1];
      nxt.zero = (result == '0);
      nxt.cy   = cy_next;
      nxt.ovf  = ovf_next;
      nxt.par  = even_ones;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flags_q <= '0;
      else if (upd) flags_q <= nxt;
   end

   assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(flags_q));

   assert_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (flags_q.zero == ($past(result) == '0)));

   assert_parity_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (flags_q.par == !$countones($past(result[PAR_W-1:0]))[0]) ||
              (flags_q.par == ($countones($past(result[PAR_W-1:0])) % 2 == 0)));

endmodule

// File: rtl/flag_alu_branch.sv
module flag_alu_branch
   import flag_alu_pkg::*;
(
   input  cc_t        flags,
   input  logic [2:0] cond,
   output logic       taken
);

   logic less;
   logic less_eq;

   assign less    = flags.sign ^ flags.ovf;
   assign less_eq = less | flags.zero;

   always_comb begin
      case (cond)
         BR_EQ:   taken = flags.zero;
         BR_NE:   taken = ~flags.zero;
         BR_LT:   taken = less;
         BR_LE:   taken = less_eq;
         BR_GT:   taken = ~less_eq;
         BR_GE:   taken = ~less;
         default: taken = 1'b0;
      endcase
   end

   always_comb begin
      if (cond > BR_GE) assert_reserved_cond_R8: assert (!taken);
   end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import flag_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int PARITY_W     = 8,
   parameter bit BARREL_SHIFT = 1'b1,
   localparam int SH_W        = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [2:0]        br_cond,
   output logic [DATA_W-1:0] res_data,
   output logic              res_write,
   output logic              br_taken,
   output logic              flag_sign,
   output logic              flag_zero,
   output logic              flag_carry,
   output logic              flag_ovf,
   output logic              flag_parity
);

   initial begin
      assert_width_pow2: assert (DATA_W >= 8 && (DATA_W & (DATA_W - 1)) == 0)
         else $error("DATA_W must be a power of two of at least 8");
      assert_parity_span: assert (PARITY_W >= 1 && PARITY_W <= DATA_W)
         else $error("PARITY_W must lie between 1 and DATA_W");
   end

   cc_t               flags_q;
   logic [1:0]        ar_mode;
   logic [1:0]        sh_kind;
   logic [DATA_W-1:0] ar_sum, sh_res, lg_res, result;
   logic              ar_carry, ar_ovf, sh_cout, sh_moved;
   logic              use_ar, use_sh, legal, upd;
   carry_src_e        cy_src;
   logic              cy_next, ovf_next;

   always_comb begin
      ar_mode = AR_ADD;
      sh_kind = SH_LEFT;
      lg_res  = '0;
      use_ar  = 1'b0;
      use_sh  = 1'b0;
      cy_src  = CY_KEEP;
      case (op_code)
         OP_ADD: begin ar_mode = AR_ADD; use_ar = 1'b1; cy_src = CY_ARITH; end
         OP_SUB,
         OP_CMP: begin ar_mode = AR_SUB; use_ar = 1'b1; cy_src = CY_ARITH; end
         OP_INC: begin ar_mode = AR_INC; use_ar = 1'b1; cy_src = CY_KEEP;  end
         OP_DEC: begin ar_mode = AR_DEC; use_ar = 1'b1; cy_src = CY_KEEP;  end
         OP_AND: begin lg_res = op_a & op_b; cy_src = CY_CLEAR; end
         OP_OR:  begin lg_res = op_a | op_b; cy_src = CY_CLEAR; end
         OP_XOR: begin lg_res = op_a ^ op_b; cy_src = CY_CLEAR; end
         OP_SLL: begin sh_kind = SH_LEFT; use_sh = 1'b1; cy_src = CY_SHIFT; end
         OP_SRL: begin sh_kind = SH_RLOG; use_sh = 1'b1; cy_src = CY_SHIFT; end
         OP_SRA: begin sh_kind = SH_RARI; use_sh = 1'b1; cy_src = CY_SHIFT; end
         default: ;
      endcase
   end

   flag_alu_arith #(.W(DATA_W)) u_arith (
      .a     (op_a),
      .b     (op_b),
      .mode  (ar_mode),
      .sum   (ar_sum),
      .carry (ar_carry),
      .ovf   (ar_ovf)
   );

   flag_alu_shift #(.W(DATA_W), .BARREL(BARREL_SHIFT)) u_shift (
      .a     (op_a),
      .amt   (op_b[SH_W-1:0]),
      .kind  (sh_kind),
      .res   (sh_res),
      .cout  (sh_cout),
      .moved (sh_moved)
   );

   assign result = use_ar ? ar_sum : (use_sh ? sh_res : lg_res);

   always_comb begin
      case (cy_src)
         CY_ARITH: cy_next = ar_carry;
         CY_CLEAR: cy_next = 1'b0;
         CY_SHIFT: cy_next = sh_moved ? sh_cout : flags_q.cy;
         default:  cy_next = flags_q.cy;
      endcase
   end

   assign ovf_next = use_ar & ar_ovf;
   assign legal    = code_is_legal(op_code);
   assign upd      = op_valid & legal;

   flag_alu_ccreg #(.W(DATA_W), .PAR_W(PARITY_W)) u_ccreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (upd),
      .result   (result),
      .cy_next  (cy_next),
      .ovf_next (ovf_next),
      .flags_q  (flags_q)
   );

   flag_alu_branch u_branch (
      .flags (flags_q),
      .cond  (br_cond),
      .taken (br_taken)
   );

   assign res_data    = result;
   assign res_write   = upd && (op_code != OP_CMP);
   assign flag_sign   = flags_q.sign;
   assign flag_zero   = flags_q.zero;
   assign flag_carry  = flags_q.cy;
   assign flag_ovf    = flags_q.ovf;
   assign flag_parity = flags_q.par;

   assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_CMP) |-> !res_write);

   assert_carry_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_INC || op_code == OP_DEC))
      |=> (flag_carry == $past(flag_carry)));

   assert_logic_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR))
      |=> (!flag_carry && !flag_ovf));

   assert_reserved_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code > OP_LAST) |-> (res_data == '0 && !res_write));

   assert_shift_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code >= OP_SLL && op_code <= OP_SRA) |=> !flag_ovf);

endmodule

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic [31:0] op_a = '0, op_b = '0;
   logic [2:0]  br_cond = '0;
   logic [31:0] res_data;
   logic        res_write, br_taken;
   logic        flag_sign, flag_zero, flag_carry, flag_ovf, flag_parity;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   // reference flags
   logic m_s = 0, m_z = 0, m_c = 0, m_o = 0, m_p = 0;

   always #10 clk = ~clk;

   flag_alu u_flag_alu (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_a(op_a), .op_b(op_b), .br_cond(br_cond),
      .res_data(res_data), .res_write(res_write), .br_taken(br_taken),
      .flag_sign(flag_sign), .flag_zero(flag_zero), .flag_carry(flag_carry),
      .flag_ovf(flag_ovf), .flag_parity(flag_parity)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic ref_branch(input logic [2:0] c);
      logic lt;
      lt = m_s ^ m_o;
      case (c)
         3'd0: return m_z;
         3'd1: return !m_z;
         3'd2: return lt;
         3'd3: return lt || m_z;
         3'd4: return !(lt || m_z);
         3'd5: return !lt;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check_flags(input string req_c, input string req_o);
      chk("R2", "sign", flag_sign, m_s);
      chk("R2", "zero", flag_zero, m_z);
      chk("R2", "parity", flag_parity, m_p);
      chk(req_c, "carry", flag_carry, m_c);
      chk(req_o, "overflow", flag_ovf, m_o);
      for (int c = 0; c < 8; c++) begin
         br_cond = c[2:0];
         #1;
         chk("R8", $sformatf("branch code %0d", c), br_taken, ref_branch(c[2:0]));
      end
   endtask

   // One operation: result checked in its own cycle, flags after the edge.
   task automatic step(input logic v, input logic [3:0] op,
                       input logic [31:0] a, input logic [31:0] b);
      longint unsigned wide;
      logic [31:0] r;
      logic nc, no, legal, wr;
      int   n;
      string rc, ro;
      r = 0; nc = m_c; no = 0; legal = 1; rc = "R3"; ro = "R3";
      n = int'(b[4:0]);
      case (op)
         4'd0: begin wide = longint'(a) + longint'(b); r = wide[31:0]; nc = wide[32];
                     no = (a[31] == b[31]) && (r[31] != a[31]); end
         4'd1, 4'd10: begin r = a - b; nc = (a < b);
                     no = (a[31] != b[31]) && (r[31] != a[31]); if (op == 4'd10) rc = "R4"; end
         4'd2: begin r = a & b; nc = 0; rc = "R5"; ro = "R5"; end
         4'd3: begin r = a | b; nc = 0; rc = "R5"; ro = "R5"; end
         4'd4: begin r = a ^ b; nc = 0; rc = "R5"; ro = "R5"; end
         4'd5: begin r = a << n; if (n != 0) nc = a[32-n]; rc = "R7"; ro = "R7"; end
         4'd6: begin r = a >> n; if (n != 0) nc = a[n-1]; rc = "R7"; ro = "R7"; end
         4'd7: begin r = $unsigned($signed(a) >>> n); if (n != 0) nc = a[n-1];
                     rc = "R7"; ro = "R7"; end
         4'd8: begin r = a + 1; no = (a == 32'h7fff_ffff); rc = "R6"; end
         4'd9: begin r = a - 1; no = (a == 32'h8000_0000); rc = "R6"; end
         default: begin legal = 0; end
      endcase
      wr = v && legal && (op != 4'd10);
      @(negedge clk);
      op_valid = v; op_code = op; op_a = a; op_b = b;
      #1;
      chk(legal ? "R1" : "R9", "result", res_data, r);
      chk(op == 4'd10 ? "R4" : (legal ? "R1" : "R9"), "write", {31'd0, res_write}, {31'd0, wr});
      @(posedge clk);
      if (v && legal) begin
         m_s = r[31]; m_z = (r == 0); m_c = nc; m_o = no;
         m_p = ($countones(r[7:0]) % 2 == 0);
      end else begin
         rc = "R9"; ro = "R9";
      end
      #1;
      op_valid = 0;
      check_flags(rc, ro);
   endtask

   initial begin
      #(20 * 200000);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!finished) $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      int unused;
      unused = $urandom(17);
      repeat (3) @(posedge clk);
      #5;
      // R10: flags cleared by reset, branch outcomes on zero flags
      chk("R10", "reset flags", {27'd0, flag_ovf, flag_parity, flag_carry, flag_zero, flag_sign}, 32'd0);
      for (int c = 0; c < 8; c++) begin
         br_cond = c[2:0];
         #1;
         chk("R10", $sformatf("reset branch %0d", c), br_taken,
             (c == 1 || c == 4 || c == 5) ? 1'b1 : 1'b0);
      end
      @(negedge clk);
      rst_n = 1'b1;

      step(1, 4'd0, 32'h7fff_ffff, 32'h1);          // R3 signed overflow
      step(1, 4'd0, 32'hffff_ffff, 32'h1);          // R3 carry, R2 zero
      step(1, 4'd8, 32'h7fff_ffff, 32'h0);          // R6 inc keeps carry=1
      step(1, 4'd1, 32'h5, 32'h9);                  // R3 borrow
      step(1, 4'd10, 32'h1234, 32'h1234);           // R4 equal
      step(1, 4'd10, 32'hffff_fff0, 32'h3);         // R4 signed less
      step(1, 4'd10, 32'h8000_0000, 32'h1);         // R4 overflow path
      step(1, 4'd10, 32'h40, 32'hffff_ff00);        // R8 greater
      step(1, 4'd2, 32'hf0f0_f0f0, 32'h0f0f_0f0f);  // R5 zero result
      step(1, 4'd3, 32'h8000_0000, 32'h3);          // R5
      step(1, 4'd4, 32'hff, 32'h1);                 // R2 parity odd
      step(1, 4'd5, 32'h8000_0001, 32'd1);          // R7 carry out left
      step(1, 4'd5, 32'h1, 32'd0);                  // R7 shift by zero
      step(1, 4'd6, 32'h3, 32'd1);                  // R7 right carry
      step(1, 4'd7, 32'h8000_0010, 32'd5);          // R7 arithmetic
      step(1, 4'd9, 32'h8000_0000, 32'h0);          // R6 dec overflow
      step(1, 4'd12, 32'h1, 32'h1);                 // R9 reserved
      step(0, 4'd0, 32'hffff_ffff, 32'h1);          // R9 invalid cycle
      for (int i = 0; i < 400; i++) begin
         logic [31:0] ra, rb;
         logic [3:0]  ro;
         ra = $urandom; rb = $urandom; ro = 4'($urandom);
         if (i % 5 == 0) rb = ra;
         step((i % 7) != 3, ro, ra, rb);
      end
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule